// File: doc/BRIEF.md
# Flash Page Merge Controller

This block fronts an on-chip non-volatile code memory with a four-register byte interface. Firmware enters load mode, deposits between one and a full page's worth of bytes into a page buffer at chosen offsets, points the address register at a page, and issues one merge command. The controller then erases and reprograms only the bytes that were loaded. Every other byte of that page keeps its value.

A merge is refused without any array activity in two cases: the brown-out inhibit input is high, or the page lies in a sector whose lock bit is set. A refused merge raises a failure flag. An accepted merge keeps the controller busy for two timed phases, each worth 2 ms of the clock. Erase comes first and program second, so the whole merge takes 4 ms. The memory array is a behavioural model made of sectors, each divided into pages. It can be read through a separate byte read port.

Register map (`reg_sel`): 0 = control (a write is a command, a read is status), 1 = address low byte, 2 = address high byte, 3 = buffer data (write only, reads 0). Status bits: bit0 busy, bit1 refused, bit2 unknown command, all other bits 0. Command codes: 0x00 enter load mode, 0x68 merge, 0x01 drop all loaded bytes.

Top module: `flash_merge_ctrl`

## Requirements
- R1: After reset the status reads 0x00, both address bytes read 0x00 and every array byte reads 0xFF.
- R2: A data write (`reg_sel`=3) stores the byte in the buffer at the offset given by the low address bits and marks that byte as loaded, but only while in load mode (after command 0x00 and before any other command); otherwise it is ignored.
- R3: An accepted merge (command 0x68) replaces exactly the loaded bytes of the page selected by the upper address bits with their buffer values; every other byte of the page and the array keeps its value.
- R4: An accepted merge keeps status bit0 high for exactly 2*PHASE_CYC clock cycles, starting with the cycle after the command write.
- R5: During an accepted merge, the loaded bytes read 0xFF from the cycle after the erase phase ends (PHASE_CYC cycles after the command) until the program phase ends.
- R6: A merge issued while `brownout` is high sets status bit1, leaves bit0 low, leaves the array unchanged and keeps the loaded bytes for a later merge.
- R7: A merge on a page whose sector has its `sector_lock` bit set behaves like R6.
- R8: A command write with a code other than 0x00, 0x01 or 0x68 sets status bit2 and has no other effect.
- R9: Every accepted command write first clears status bits 1 and 2.
- R10: While status bit0 is high, all register writes are ignored: commands, address bytes and buffer data.
- R11: The loaded marks clear when a merge completes and on command 0x01, so that a following merge with nothing loaded changes no byte.
- R12: The address bytes read back what was written, with bits above the array's address width reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| brownout | input | 1 | Supply-low inhibit for erase and program |
| sector_lock | input | NUM_SECTORS | Per-sector write protection |
| rd_addr | input | ADDR_W | Array read byte address |
| rd_data | output | 8 | Array read data |

## Verification
The bench builds the block with the default geometry: two sectors of 1024 bytes, each split into pages of 64 bytes. With this geometry, one page in an open sector and one page in a locked sector can both be exercised. It sets CLK_KHZ to 10, which gives 20-cycle phases. The full 40-cycle busy window can then be counted exactly, and the erased state in the middle of a merge can be seen in a short run. A full-page fill followed by a sparse merge from a vector table shows that unloaded bytes are preserved.

// File: rtl/fmc_pkg.sv
`timescale 1ns/1ps
package fmc_pkg;
   localparam logic [7:0] CMD_LOAD  = 8'h00;
   localparam logic [7:0] CMD_CLEAR = 8'h01;
   localparam logic [7:0] CMD_MERGE = 8'h68;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_ADLO = 2'd1,
      SEL_ADHI = 2'd2,
      SEL_DATA = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ERASE = 2'd1,
      SQ_PROG  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/fmc_regif.sv
`timescale 1ns/1ps
module fmc_regif
   import fmc_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic              busy,
   input  logic              brownout,
   input  logic              lock_hit,
   output logic [ADDR_W-1:0] addr_q,
   output logic              buf_we,
   output logic              buf_clr_cmd,
   output logic              start,
   output logic              stat_fail,
   output logic              stat_illegal
);
   logic wr_ok, ctrl_wr, is_known, load_en;
   logic [15:0] addr_full;

   assign wr_ok       = reg_wr && !busy;
   assign ctrl_wr     = wr_ok && (reg_sel == SEL_CTRL);
   assign is_known    = (reg_wdata == CMD_LOAD) || (reg_wdata == CMD_CLEAR) ||
                        (reg_wdata == CMD_MERGE);
   assign start       = ctrl_wr && (reg_wdata == CMD_MERGE) && !brownout && !lock_hit;
   assign buf_clr_cmd = ctrl_wr && (reg_wdata == CMD_CLEAR);
   assign buf_we      = wr_ok && (reg_sel == SEL_DATA) && load_en;
   assign addr_full   = 16'(addr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q       <= '0;
         load_en      <= 1'b0;
         stat_fail    <= 1'b0;
         stat_illegal <= 1'b0;
      end else if (wr_ok) begin
         unique case (reg_sel)
            SEL_CTRL: begin
               load_en      <= (reg_wdata == CMD_LOAD);
               stat_illegal <= !is_known;
               stat_fail    <= (reg_wdata == CMD_MERGE) && (brownout || lock_hit);
            end
            SEL_ADLO: addr_q <= ADDR_W'({addr_full[15:8], reg_wdata});
            SEL_ADHI: addr_q <= ADDR_W'({reg_wdata, addr_full[7:0]});
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fmc_pagebuf.sv
`timescale 1ns/1ps
module fmc_pagebuf #(
   parameter int PAGE_BYTES = 64,
   localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [OFS_W-1:0]        ofs,
   input  logic [7:0]              wdata,
   input  logic                    clr,
   output logic [PAGE_BYTES*8-1:0] data_flat,
   output logic [PAGE_BYTES-1:0]   valid
);
   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
      logic hit;
      assign hit = we && (ofs == OFS_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_flat[g*8 +: 8] <= 8'hFF;
            valid[g]            <= 1'b0;
         end else if (clr) begin
            valid[g]            <= 1'b0;
         end else if (hit) begin
            data_flat[g*8 +: 8] <= wdata;
            valid[g]            <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fmc_seq.sv
`timescale 1ns/1ps
module fmc_seq
   import fmc_pkg::*;
#(
   parameter int PHASE_CYC = 20,
   localparam int CNT_W    = $clog2(PHASE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic erase_stb,
   output logic prog_stb
);
   seq_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             last;

   assign last      = (cnt == CNT_W'(PHASE_CYC - 1));
   assign busy      = (state != SQ_IDLE);
   assign erase_stb = (state == SQ_ERASE) && last;
   assign prog_stb  = (state == SQ_PROG) && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (start) begin
               state <= SQ_ERASE;
               cnt   <= '0;
            end
            SQ_ERASE: begin
               cnt <= last ? '0 : cnt + 1'b1;
               if (last) state <= SQ_PROG;
            end
            SQ_PROG: begin
               cnt <= last ? '0 : cnt + 1'b1;
               if (last) state <= SQ_IDLE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fmc_array.sv
`timescale 1ns/1ps
module fmc_array #(
   parameter int ADDR_W     = 11,
   parameter int PAGE_BYTES = 64,
   localparam int OFS_W     = $clog2(PAGE_BYTES),
   localparam int PG_W      = ADDR_W - OFS_W,
   localparam int DEPTH     = 1 << ADDR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    erase_stb,
   input  logic                    prog_stb,
   input  logic [PG_W-1:0]         page,
   input  logic [PAGE_BYTES-1:0]   valid,
   input  logic [PAGE_BYTES*8-1:0] data_flat,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [7:0]              rd_data
);
   logic [7:0] mem [DEPTH];

   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
      end else begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (valid[i] && erase_stb) mem[{page, OFS_W'(i)}] <= 8'hFF;
            if (valid[i] && prog_stb)  mem[{page, OFS_W'(i)}] <= data_flat[i*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/flash_merge_ctrl.sv
`timescale 1ns/1ps
module flash_merge_ctrl
   import fmc_pkg::*;
#(
   parameter int PAGE_BYTES   = 64,
   parameter int SECTOR_BYTES = 1024,
   parameter int NUM_SECTORS  = 2,
   parameter int CLK_KHZ      = 12000,
   localparam int ADDR_W      = $clog2(NUM_SECTORS * SECTOR_BYTES),
   localparam int OFS_W       = $clog2(PAGE_BYTES),
   localparam int SEC_LSB     = $clog2(SECTOR_BYTES),
   localparam int PHASE_CYC   = 2 * CLK_KHZ
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [1:0]             reg_sel,
   input  logic [7:0]             reg_wdata,
   output logic [7:0]             reg_rdata,
   input  logic                   brownout,
   input  logic [NUM_SECTORS-1:0] sector_lock,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [7:0]             rd_data
);
   if ((1 << OFS_W) != PAGE_BYTES || (1 << SEC_LSB) != SECTOR_BYTES)
      $error("page and sector sizes must be powers of two");
   if (SECTOR_BYTES < PAGE_BYTES) $error("sector smaller than page");
   if (ADDR_W > 16) $error("array exceeds the 16-bit address register");
   if (CLK_KHZ < 1) $error("CLK_KHZ must be positive");

   logic [ADDR_W-1:0]       addr_q;
   logic                    buf_we, buf_clr_cmd, start, stat_fail, stat_illegal;
   logic                    stat_busy, erase_stb, prog_stb, lock_hit;
   logic [PAGE_BYTES*8-1:0] buf_data;
   logic [PAGE_BYTES-1:0]   buf_valid;
   logic [15:0]             addr_full;

   if (NUM_SECTORS == 1) begin : g_one_sector
      assign lock_hit = sector_lock[0];
   end else begin : g_multi_sector
      assign lock_hit = sector_lock[addr_q[ADDR_W-1:SEC_LSB]];
   end

   fmc_regif #(.ADDR_W(ADDR_W)) u_regif (
      .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata,
      .busy(stat_busy), .brownout, .lock_hit, .addr_q,
      .buf_we, .buf_clr_cmd, .start, .stat_fail, .stat_illegal
   );

   fmc_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
      .clk, .rst_n, .we(buf_we), .ofs(addr_q[OFS_W-1:0]), .wdata(reg_wdata),
      .clr(buf_clr_cmd || prog_stb), .data_flat(buf_data), .valid(buf_valid)
   );

   fmc_seq #(.PHASE_CYC(PHASE_CYC)) u_seq (
      .clk, .rst_n, .start, .busy(stat_busy), .erase_stb, .prog_stb
   );

   fmc_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
      .clk, .rst_n, .erase_stb, .prog_stb, .page(addr_q[ADDR_W-1:OFS_W]),
      .valid(buf_valid), .data_flat(buf_data), .rd_addr, .rd_data
   );

   assign addr_full = 16'(addr_q);
   always_comb begin
      unique case (reg_sel)
         SEL_CTRL: reg_rdata = {5'b0, stat_illegal, stat_fail, stat_busy};
         SEL_ADLO: reg_rdata = addr_full[7:0];
         SEL_ADHI: reg_rdata = addr_full[15:8];
         default:  reg_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/fmc_checker.sv
`timescale 1ns/1ps
module fmc_checker #(
   parameter int PHASE_CYC = 20,
   parameter int ADDR_W    = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_sel,
   input logic [7:0]        reg_wdata,
   input logic              brownout,
   input logic              busy,
   input logic              fail,
   input logic              illegal,
   input logic [ADDR_W-1:0] addr_q
);
   logic [31:0] run;
   logic        idle_cmd;

   assign idle_cmd = reg_wr && !busy && (reg_sel == 2'd0);

   always_ff @(posedge clk) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 1;
      else           run <= '0;
   end

   assert_busy_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run == 32'(2 * PHASE_CYC)));

   assert_brownout_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cmd && reg_wdata == 8'h68 && brownout) |=> (!busy && fail));

   assert_unknown_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cmd && reg_wdata != 8'h00 && reg_wdata != 8'h01 && reg_wdata != 8'h68)
      |=> (illegal && !fail && !busy));

   assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cmd && (reg_wdata == 8'h00 || reg_wdata == 8'h01)) |=> (!fail && !illegal));

   assert_busy_locks_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr) |=> $stable(addr_q));
endmodule

bind flash_merge_ctrl fmc_checker #(.PHASE_CYC(PHASE_CYC), .ADDR_W(ADDR_W)) u_chk (
   .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .brownout,
   .busy(stat_busy), .fail(stat_fail), .illegal(stat_illegal), .addr_q
);

// File: tb/tb_flash_merge_ctrl.sv
`timescale 1ns/1ps
module tb_flash_merge_ctrl;
   localparam int PHASE = 20;
   localparam int NV    = 8;
   localparam int PAGEA = 5;    // sector 0
   localparam int PAGEL = 20;   // sector 1
   localparam logic [13:0] VEC [NV] = '{
      {6'd0, 8'h11}, {6'd3, 8'h00}, {6'd7, 8'h5A}, {6'd15, 8'hC3},
      {6'd31, 8'h7E}, {6'd32, 8'h01}, {6'd62, 8'hFE}, {6'd63, 8'h80}};

   logic clk = 0, rst_n = 0, reg_wr = 0, brownout = 0;
   logic [1:0] reg_sel = 0, sector_lock = 0;
   logic [7:0] reg_wdata = 0, reg_rdata, rd_data;
   logic [10:0] rd_addr = 0;
   int nchk = 0, nerr = 0;
   logic [7:0] exp_pg [64];

   flash_merge_ctrl #(.CLK_KHZ(10)) dut (.*);

   always #5 clk = ~clk;

   task automatic chk(string req, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] s, logic [7:0] d);
      @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic rdreg(logic [1:0] s, output logic [7:0] v);
      reg_sel = s; #1 v = reg_rdata;
   endtask

   task automatic rdmem(int a, output logic [7:0] v);
      rd_addr = 11'(a); #1 v = rd_data;
   endtask

   task automatic set_addr(int a);
      wr(2'd1, 8'(a)); wr(2'd2, 8'(a >> 8));
   endtask

   task automatic load(int ofs, logic [7:0] d);
      wr(2'd1, 8'(ofs)); wr(2'd3, d);
   endtask

   task automatic wait_idle(output int n);
      logic [7:0] s;
      n = 0;
      rdreg(2'd0, s);
      while (s[0] && n < 1000) begin
         n++; @(negedge clk); rdreg(2'd0, s);
      end
   endtask

   task automatic check_page(int pg, string req);
      logic [7:0] v;
      int bad = 0, firstv = 0, firste = 0;
      for (int i = 0; i < 64; i++) begin
         rdmem(pg * 64 + i, v);
         if (v != exp_pg[i] && bad == 0) begin firstv = v; firste = exp_pg[i]; end
         if (v != exp_pg[i]) bad++;
      end
      chk(req, bad == 0 ? 0 : firstv, bad == 0 ? 0 : firste);
   endtask

   initial begin : watchdog
      #(200000 * 10);
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rdreg(2'd0, v); chk("R1 status", v, 8'h00);
      rdreg(2'd1, v); chk("R1 addr lo", v, 8'h00);
      rdreg(2'd2, v); chk("R1 addr hi", v, 8'h00);
      rdmem(0, v);    chk("R1 array first", v, 8'hFF);
      rdmem(2047, v); chk("R1 array last", v, 8'hFF);
      // R12 address readback, upper bits above 11 read 0
      set_addr(16'hFABC);
      rdreg(2'd1, v); chk("R12 lo", v, 8'hBC);
      rdreg(2'd2, v); chk("R12 hi", v, 8'h02);
      // fill whole page A
      wr(2'd0, 8'h00);
      for (int i = 0; i < 64; i++) begin
         exp_pg[i] = 8'(8'hA0 ^ i);
         load(PAGEA * 64 + i, exp_pg[i]);
      end
      set_addr(PAGEA * 64);
      wr(2'd0, 8'h68);
      wait_idle(n);
      chk("R4 busy cycles full page", n, 2 * PHASE);
      check_page(PAGEA, "R3 full fill");
      // sparse merge from table
      wr(2'd0, 8'h00);
      for (int k = 0; k < NV; k++) begin
         load(PAGEA * 64 + int'(VEC[k][13:8]), VEC[k][7:0]);
         exp_pg[VEC[k][13:8]] = VEC[k][7:0];
      end
      set_addr(PAGEA * 64 + 9);
      wr(2'd0, 8'h68);
      n = 0;
      rdreg(2'd0, v);
      while (v[0] && n < 1000) begin
         n++;
         if (n == PHASE + 2) begin
            rdmem(PAGEA * 64 + 7, v); chk("R5 erased mid-merge", v, 8'hFF);
            rdmem(PAGEA * 64 + 8, v); chk("R5 unloaded kept mid-merge", v, 8'(8'hA0 ^ 8));
         end
         @(negedge clk); rdreg(2'd0, v);
      end
      chk("R4 busy cycles sparse", n, 2 * PHASE);
      check_page(PAGEA, "R3 sparse merge");
      rdmem(PAGEA * 64 + 64, v); chk("R3 next page untouched", v, 8'hFF);
      // R11 marks clear after completion
      wr(2'd0, 8'h68); wait_idle(n);
      check_page(PAGEA, "R11 empty merge after completion");
      // R11 clear command
      wr(2'd0, 8'h00); load(PAGEA * 64 + 2, 8'h3C); wr(2'd0, 8'h01);
      set_addr(PAGEA * 64); wr(2'd0, 8'h68); wait_idle(n);
      check_page(PAGEA, "R11 clear command");
      // R2 data write outside load mode ignored
      load(PAGEA * 64 + 4, 8'h99);
      set_addr(PAGEA * 64); wr(2'd0, 8'h68); wait_idle(n);
      check_page(PAGEA, "R2 data outside load mode");
      // R6 brownout refuses, keeps marks
      wr(2'd0, 8'h00); load(PAGEA * 64 + 5, 8'h42);
      set_addr(PAGEA * 64);
      brownout = 1; wr(2'd0, 8'h68); brownout = 0;
      rdreg(2'd0, v); chk("R6 refused status", v, 8'h02);
      check_page(PAGEA, "R6 array unchanged");
      wr(2'd0, 8'h68); wait_idle(n);
      chk("R6 retry busy cycles", n, 2 * PHASE);
      exp_pg[5] = 8'h42;
      check_page(PAGEA, "R6 marks kept for retry");
      // R7 locked sector
      sector_lock = 2'b10;
      for (int i = 0; i < 64; i++) exp_pg[i] = 8'hFF;
      wr(2'd0, 8'h00); load(PAGEL * 64 + 1, 8'h10);
      set_addr(PAGEL * 64); wr(2'd0, 8'h68);
      rdreg(2'd0, v); chk("R7 refused status", v, 8'h02);
      check_page(PAGEL, "R7 locked page unchanged");
      // R9 clear of refused flag
      wr(2'd0, 8'h01);
      rdreg(2'd0, v); chk("R9 clear after refuse", v, 8'h00);
      sector_lock = 2'b00;
      // R8 unknown command
      wr(2'd0, 8'h55);
      rdreg(2'd0, v); chk("R8 unknown status", v, 8'h04);
      wr(2'd0, 8'h00);
      rdreg(2'd0, v); chk("R9 clear after unknown", v, 8'h00);
      // R10 writes during busy ignored
      load(PAGEL * 64 + 1, 8'h10);
      set_addr(PAGEL * 64); wr(2'd0, 8'h68);
      wr(2'd1, 8'h33); wr(2'd3, 8'h77); wr(2'd0, 8'h55); wr(2'd2, 8'h00);
      wait_idle(n);
      rdreg(2'd0, v); chk("R10 command ignored", v, 8'h00);
      rdreg(2'd1, v); chk("R10 addr lo ignored", v, 8'h00);
      rdreg(2'd2, v); chk("R10 addr hi ignored", v, 8'h05);
      exp_pg[1] = 8'h10;
      check_page(PAGEL, "R10 merge completes unchanged");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end
endmodule